// File: doc/BRIEF.md
# Asynchronous Memory Strobe Controller

This block runs one read or one write at a time against an external asynchronous memory. A request carries address, byte enables, write data and direction. The controller then drives active-low chip enable, byte enables, output enable and read and write strobes, along with address, write data and a write-data drive enable. Each access passes through a setup phase, a strobe phase and a hold phase. Each phase has its own cycle count, and reads and writes have separate sets of counts. For reads, the data on the memory bus is captured when the strobe ends, and a one-cycle completion pulse returns it to the requester.

A ready line from the memory may stretch the strobe phase. The line is asynchronous, so it passes through an internal synchronizer, and a high level counts as a release only when it has lasted long enough. Stretching is allowed only when setup plus strobe reaches a minimum of four cycles. After every access, chip enable stays low for a trailing period whose length depends on the direction and on the hold count. A new request may be accepted during that period, and it cuts the period short.

Top module: `async_mem_strobe_ctrl`

## Requirements
- R1: After reset, mem_ce_no, mem_oe_no, mem_re_no, mem_we_no and every bit of mem_be_no are 1. mem_wdata_oe_o and rsp_done_o are 0, and req_ready_o is 1.
- R2: A request is taken on a clock edge where req_valid_i and req_ready_o are both 1. req_ready_o is 1 only while the controller is idle or in its trailing period. While an access runs, mem_addr_o, mem_be_no (the inverse of req_be_i, bit for bit) and, for writes, mem_wdata_o hold the accepted values from the first setup cycle to the last hold cycle. A request offered while req_ready_o is 0 has no effect.
- R3: The setup phase lasts the programmed setup count (cfg_rd_setup_i for reads, cfg_wr_setup_i for writes). During this phase chip enable is low and both strobes are high. A count of 0 removes the phase.
- R4: If ready stretching is not in effect, the strobe (mem_re_no for reads, mem_we_no for writes) stays low for exactly the programmed strobe count. A count of 0 acts as 1.
- R5: Ready stretching applies only when setup plus the effective strobe count is 4 or more. In that case the strobe stays low past its count until a release is recognized. It rises at the third clock edge after the edge that first samples mem_rdy_i high, but never before the programmed count has elapsed. When the sum is below 4, mem_rdy_i has no effect on strobe width.
- R6: mem_rdy_i must be sampled high on two consecutive edges to count as a release. A high level seen at only one edge does not end a stretched strobe.
- R7: The hold phase lasts the programmed hold count, with the strobes high and the access signals still driven. A count of 0 removes the phase.
- R8: A read holds mem_oe_no low, and a write holds mem_wdata_oe_o high, from the first setup cycle to the last hold cycle. Only the strobe for the access direction ever goes low, and it goes low only while chip enable is low.
- R9: rsp_done_o is high for exactly one cycle, in the cycle right after the last strobe cycle, for reads and for writes. For a read, rsp_rdata_o then holds the mem_rdata_i value present during the last strobe cycle.
- R10: After a read, chip enable stays low for 7 minus the read hold count further cycles, or for none if the hold count is 7 or more.
- R11: After a write, chip enable stays low for 3 further cycles when the write hold count is 1 or more, and for 4 cycles when it is 0.
- R12: A request accepted during the trailing period ends it at once. Chip enable stays low without a gap, and the new access begins in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Controller can take a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Access address |
| req_be_i | input | DATA_W/8 | Byte enables, active high |
| req_wdata_i | input | DATA_W | Write data |
| cfg_rd_setup_i | input | CNT_W | Read setup cycles |
| cfg_rd_strobe_i | input | CNT_W | Read strobe cycles |
| cfg_rd_hold_i | input | CNT_W | Read hold cycles |
| cfg_wr_setup_i | input | CNT_W | Write setup cycles |
| cfg_wr_strobe_i | input | CNT_W | Write strobe cycles |
| cfg_wr_hold_i | input | CNT_W | Write hold cycles |
| mem_ce_no | output | 1 | Chip enable, active low |
| mem_be_no | output | DATA_W/8 | Byte enables, active low |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_oe_no | output | 1 | Output enable, active low, reads |
| mem_re_no | output | 1 | Read strobe, active low |
| mem_we_no | output | 1 | Write strobe, active low |
| mem_wdata_o | output | DATA_W | Write data to memory |
| mem_wdata_oe_o | output | 1 | Write data drive enable |
| mem_rdata_i | input | DATA_W | Read data from memory |
| mem_rdy_i | input | 1 | Asynchronous memory ready |
| rsp_done_o | output | 1 | Access complete pulse |
| rsp_rdata_o | output | DATA_W | Captured read data |

## Verification
The hardest situation to reach is a stretched strobe whose release arrives at a known edge. Reaching it requires the ready line to be low for long enough beforehand that the synchronizer and its recognition window are both empty. The stimulus lowers ready several idle cycles before the request. A negative-edge monitor then raises it in a chosen strobe cycle, which fixes the sampling edge and lets the bench predict the exact width. Variants add a one-cycle glitch ahead of the real release, and use a setup plus strobe sum of three so that stretching must not happen.

// File: rtl/amsc_pkg.sv
package amsc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_TAIL
  } phase_e;

  localparam int RD_TAIL_SPAN      = 7;
  localparam int WR_TAIL_HOLD      = 3;
  localparam int WR_TAIL_ZERO_HOLD = 4;
  localparam int EXT_MIN_SUM       = 4;
endpackage

// File: rtl/amsc_rdy_sync.sv
module amsc_rdy_sync #(
  parameter int unsigned STAGES   = 2,
  parameter int unsigned MIN_HIGH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rdy_i,
  output logic release_o
);
  localparam int unsigned HIST_W = (MIN_HIGH > 1) ? MIN_HIGH - 1 : 1;

  logic [STAGES-1:0] sync_q;
  logic              rdy_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[STAGES-2:0], rdy_i};
  end
  assign rdy_s = sync_q[STAGES-1];

  generate
    if (MIN_HIGH > 1) begin : g_window
      logic [HIST_W-1:0] hist_q;
      if (HIST_W > 1) begin : g_shift
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) hist_q <= '1;
          else         hist_q <= {hist_q[HIST_W-2:0], rdy_s};
        end
      end else begin : g_single
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) hist_q <= '1;
          else         hist_q <= rdy_s;
        end
      end
      assign release_o = rdy_s & (&hist_q);
    end else begin : g_direct
      assign release_o = rdy_s;
    end
  endgenerate
endmodule

// File: rtl/amsc_tail_cnt.sv
module amsc_tail_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             clear_i,
  output logic             active_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clear_i)        cnt_q <= '0;
    else if (load_i)         cnt_q <= len_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  assign active_o = (cnt_q != '0);
  assign last_o   = (cnt_q == CNT_W'(1));

  AST_TAIL_LOAD_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !clear_i |=> active_o) else $error("tail load of zero length"); // R10
endmodule

// File: rtl/async_mem_strobe_ctrl.sv
module async_mem_strobe_ctrl
  import amsc_pkg::*;
#(
  parameter int unsigned ADDR_W       = 20,
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned CNT_W        = 4,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned RDY_MIN_HIGH = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic                req_write_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [DATA_W/8-1:0] req_be_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  input  logic [CNT_W-1:0]    cfg_rd_setup_i,
  input  logic [CNT_W-1:0]    cfg_rd_strobe_i,
  input  logic [CNT_W-1:0]    cfg_rd_hold_i,
  input  logic [CNT_W-1:0]    cfg_wr_setup_i,
  input  logic [CNT_W-1:0]    cfg_wr_strobe_i,
  input  logic [CNT_W-1:0]    cfg_wr_hold_i,
  output logic                mem_ce_no,
  output logic [DATA_W/8-1:0] mem_be_no,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic                mem_oe_no,
  output logic                mem_re_no,
  output logic                mem_we_no,
  output logic [DATA_W-1:0]   mem_wdata_o,
  output logic                mem_wdata_oe_o,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  input  logic                mem_rdy_i,
  output logic                rsp_done_o,
  output logic [DATA_W-1:0]   rsp_rdata_o
);
  localparam int unsigned BE_W = DATA_W / 8;
  localparam int unsigned SUM_W = CNT_W + 1;

  phase_e           state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] str_q, hold_q, tail_q;
  logic             ext_q, dir_q;
  logic [BE_W-1:0]  be_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic             done_q;

  logic             accept, strobe_end, tail_load, tail_clr;
  logic             rdy_rel, tail_active, tail_last;
  logic [CNT_W-1:0] sel_setup, sel_str, sel_hold, sel_tail;
  logic [SUM_W-1:0] sel_sum;
  logic             sel_ext;
  phase_e           start_state;
  logic [CNT_W-1:0] start_cnt;

  amsc_rdy_sync #(.STAGES(SYNC_STAGES), .MIN_HIGH(RDY_MIN_HIGH)) u_rdy_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rdy_i     (mem_rdy_i),
    .release_o (rdy_rel)
  );

  amsc_tail_cnt #(.CNT_W(CNT_W)) u_tail_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tail_load),
    .len_i    (tail_q),
    .clear_i  (tail_clr),
    .active_o (tail_active),
    .last_o   (tail_last)
  );

  assign req_ready_o = (state_q == ST_IDLE) || (state_q == ST_TAIL);
  assign accept      = req_valid_i && req_ready_o;

  // per-direction timing picked at acceptance
  always_comb begin
    if (req_write_i) begin
      sel_setup = cfg_wr_setup_i;
      sel_str   = (cfg_wr_strobe_i == '0) ? CNT_W'(1) : cfg_wr_strobe_i;
      sel_hold  = cfg_wr_hold_i;
      sel_tail  = (cfg_wr_hold_i == '0) ? CNT_W'(WR_TAIL_ZERO_HOLD) : CNT_W'(WR_TAIL_HOLD);
    end else begin
      sel_setup = cfg_rd_setup_i;
      sel_str   = (cfg_rd_strobe_i == '0) ? CNT_W'(1) : cfg_rd_strobe_i;
      sel_hold  = cfg_rd_hold_i;
      sel_tail  = (cfg_rd_hold_i >= CNT_W'(RD_TAIL_SPAN)) ? '0
                : CNT_W'(RD_TAIL_SPAN) - cfg_rd_hold_i;
    end
    sel_sum     = {1'b0, sel_setup} + {1'b0, sel_str};
    sel_ext     = (sel_sum >= SUM_W'(EXT_MIN_SUM));
    start_state = (sel_setup != '0) ? ST_SETUP : ST_STROBE;
    start_cnt   = (sel_setup != '0) ? sel_setup : sel_str;
  end

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    strobe_end = 1'b0;
    tail_load  = 1'b0;
    tail_clr   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = start_state;
          cnt_d   = start_cnt;
        end
      end
      ST_SETUP: begin
        if (cnt_q <= CNT_W'(1)) begin
          state_d = ST_STROBE;
          cnt_d   = str_q;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_STROBE: begin
        if (cnt_q > CNT_W'(1)) begin
          cnt_d = cnt_q - CNT_W'(1);
        end else if (!ext_q || rdy_rel) begin
          strobe_end = 1'b1;
          if (hold_q != '0) begin
            state_d = ST_HOLD;
            cnt_d   = hold_q;
          end else if (tail_q != '0) begin
            state_d   = ST_TAIL;
            tail_load = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_HOLD: begin
        if (cnt_q <= CNT_W'(1)) begin
          if (tail_q != '0) begin
            state_d   = ST_TAIL;
            tail_load = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_TAIL: begin
        if (accept) begin
          tail_clr = 1'b1;
          state_d  = start_state;
          cnt_d    = start_cnt;
        end else if (tail_last || !tail_active) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  logic            dir_d, acc_d;
  logic [BE_W-1:0] be_d;
  assign dir_d = accept ? req_write_i : dir_q;
  assign be_d  = accept ? req_be_i : be_q;
  assign acc_d = (state_d == ST_SETUP) || (state_d == ST_STROBE) || (state_d == ST_HOLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      str_q   <= CNT_W'(1);
      hold_q  <= '0;
      tail_q  <= '0;
      ext_q   <= 1'b0;
      dir_q   <= 1'b0;
      be_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      dir_q   <= dir_d;
      be_q    <= be_d;
      if (accept) begin
        str_q   <= sel_str;
        hold_q  <= sel_hold;
        tail_q  <= sel_tail;
        ext_q   <= sel_ext;
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
    end
  end

  // pins registered from next-state decode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_ce_no      <= 1'b1;
      mem_oe_no      <= 1'b1;
      mem_re_no      <= 1'b1;
      mem_we_no      <= 1'b1;
      mem_be_no      <= '1;
      mem_wdata_oe_o <= 1'b0;
      done_q         <= 1'b0;
      rdata_q        <= '0;
    end else begin
      mem_ce_no      <= (state_d == ST_IDLE);
      mem_oe_no      <= !(acc_d && !dir_d);
      mem_re_no      <= !((state_d == ST_STROBE) && !dir_d);
      mem_we_no      <= !((state_d == ST_STROBE) && dir_d);
      mem_be_no      <= acc_d ? ~be_d : '1;
      mem_wdata_oe_o <= acc_d && dir_d;
      done_q         <= strobe_end;
      if (strobe_end && !dir_q) rdata_q <= mem_rdata_i;
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign rsp_done_o  = done_q;
  assign rsp_rdata_o = rdata_q;

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_re_no && !mem_we_no)) else $error("both strobes low"); // R8
  AST_STROBE_IN_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_re_no || !mem_we_no) |-> !mem_ce_no) else $error("strobe without chip enable"); // R8
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD) |-> ($stable(mem_addr_o) && $stable(mem_be_no))) else $error("access fields moved in hold"); // R2
  AST_BUSY_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_ready_o) |=> $stable(mem_addr_o)) else $error("request taken while busy"); // R2
  AST_DONE_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |-> ($past(!mem_re_no || !mem_we_no) && mem_re_no && mem_we_no)) else $error("done misplaced"); // R9
  AST_NOT_READY_STRETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STROBE && cnt_q <= CNT_W'(1) && ext_q && !rdy_rel) |=> !(mem_re_no && mem_we_no))
    else $error("strobe ended without ready"); // R5
  AST_TAIL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TAIL) |-> (!mem_ce_no && mem_oe_no && !mem_wdata_oe_o && mem_re_no && mem_we_no))
    else $error("tail drives access signals"); // R12
endmodule

// File: tb/async_mem_strobe_ctrl_bench.sv
`timescale 1ns/1ps
module async_mem_strobe_ctrl_bench;
  localparam int AW = 20;
  localparam int DW = 32;
  localparam int BW = DW / 8;
  localparam int CW = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic          req_valid_i = 1'b0, req_write_i = 1'b0;
  logic          req_ready_o;
  logic [AW-1:0] req_addr_i = '0;
  logic [BW-1:0] req_be_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic [CW-1:0] cfg_rd_setup_i = '0, cfg_rd_strobe_i = '0, cfg_rd_hold_i = '0;
  logic [CW-1:0] cfg_wr_setup_i = '0, cfg_wr_strobe_i = '0, cfg_wr_hold_i = '0;
  logic          mem_ce_no, mem_oe_no, mem_re_no, mem_we_no, mem_wdata_oe_o;
  logic [BW-1:0] mem_be_no;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o, rsp_rdata_o;
  logic [DW-1:0] mem_rdata_i = '0;
  logic          mem_rdy_i = 1'b1;
  logic          rsp_done_o;

  async_mem_strobe_ctrl u_async_mem_strobe_ctrl (.*);

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  // bench state read by monitor
  logic          exp_write = 0;
  logic [AW-1:0] exp_addr = '0;
  logic [BW-1:0] exp_be = '0;
  logic [DW-1:0] exp_wdata = '0;
  int rdy_rise_k = 0, rdy_pulse_k = 0;
  bit rdy_idle_lvl = 1;

  int m_setup = 0, m_strobe = 0, m_hold = 0, m_tail = 0, m_prev_tail = 0;
  int m_done = 0, m_mism = 0;
  bit m_done_ok = 1, m_seen_stb = 0, m_prev_act = 0, m_prev_stb = 0, ce_high_seen = 0;
  logic [DW-1:0] m_rdata = '0;

  function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a);
    return {12'hC3A, a} ^ 32'h0000_5A5A;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // negedge monitor: phase counting, memory model, ready driver
  always @(negedge clk_i) begin
    bit act, stb;
    act = !mem_oe_no || mem_wdata_oe_o;
    stb = !mem_re_no || !mem_we_no;
    if (act && !m_prev_act) begin
      m_prev_tail = m_tail;
      m_setup = 0; m_strobe = 0; m_hold = 0; m_tail = 0;
      m_done = 0; m_done_ok = 1; m_mism = 0; m_seen_stb = 0;
    end
    if (act) begin
      if (stb) begin m_strobe++; m_seen_stb = 1; end
      else if (!m_seen_stb) m_setup++;
      else m_hold++;
      if (mem_addr_o != exp_addr || mem_be_no != ~exp_be || mem_ce_no) m_mism++;
      if (exp_write && (mem_wdata_o != exp_wdata || !mem_oe_no || !mem_re_no)) m_mism++;
      if (!exp_write && (mem_wdata_oe_o || !mem_we_no)) m_mism++;
    end else if (!mem_ce_no) m_tail++;
    else ce_high_seen = 1;
    if (rsp_done_o) begin
      m_done++;
      if (!m_prev_stb || stb) m_done_ok = 0;
      m_rdata = rsp_rdata_o;
    end
    mem_rdata_i = !mem_re_no ? exp_rd(mem_addr_o) : 32'hDEAD_BEEF;
    if (stb && rdy_rise_k != 0)
      mem_rdy_i = (m_strobe == rdy_pulse_k) || (m_strobe >= rdy_rise_k);
    else
      mem_rdy_i = rdy_idle_lvl;
    m_prev_act = act;
    m_prev_stb = stb;
  end

  task automatic wait_neg();
    @(negedge clk_i); #1;
  endtask

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [BW-1:0] be,
                       input logic [DW-1:0] wd);
    exp_write = wr; exp_addr = a; exp_be = be; exp_wdata = wd;
    req_write_i = wr; req_addr_i = a; req_be_i = be; req_wdata_i = wd;
    req_valid_i = 1'b1;
    @(posedge clk_i); #1;
    req_valid_i = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    do begin wait_neg(); guard++; end while (!mem_ce_no && guard < 300);
  endtask

  task automatic set_cfg(input bit wr, input int s, input int st, input int h);
    if (wr) begin
      cfg_wr_setup_i = CW'(s); cfg_wr_strobe_i = CW'(st); cfg_wr_hold_i = CW'(h);
    end else begin
      cfg_rd_setup_i = CW'(s); cfg_rd_strobe_i = CW'(st); cfg_rd_hold_i = CW'(h);
    end
  endtask

  task automatic run_access(input bit wr, input int s, input int st, input int h,
                            input int rise, input int pulse);
    int eff, exp_w, exp_tail;
    logic [AW-1:0] a;
    logic [BW-1:0] be;
    a  = AW'($urandom);
    be = BW'($urandom) | BW'(1);
    set_cfg(wr, s, st, h);
    set_cfg(!wr, $urandom % 4, $urandom % 6, $urandom % 10);
    if (rise != 0) begin
      rdy_idle_lvl = 0;
      repeat (3) wait_neg();
    end
    rdy_rise_k = rise; rdy_pulse_k = pulse;
    wait_neg();
    check(req_ready_o == 1'b1, "R2 ready when idle", req_ready_o, 1);
    issue(wr, a, be, $urandom);
    wait_idle();
    rdy_rise_k = 0; rdy_pulse_k = 0; rdy_idle_lvl = 1;
    eff = (st == 0) ? 1 : st;
    exp_w = (rise != 0 && s + eff >= 4) ? ((rise + 3 > eff) ? rise + 3 : eff) : eff;
    if (wr) exp_tail = (h == 0) ? 4 : 3;
    else    exp_tail = (h >= 7) ? 0 : 7 - h;
    check(m_setup == s, "R3 setup length", m_setup, s);
    if (rise != 0) check(m_strobe == exp_w, "R5/R6 strobe width with ready", m_strobe, exp_w);
    else           check(m_strobe == exp_w, "R4 strobe width", m_strobe, exp_w);
    check(m_hold == h, "R7 hold length", m_hold, h);
    check(m_mism == 0, "R2/R8 access signals", m_mism, 0);
    check(m_done == 1 && m_done_ok, "R9 done pulse", m_done, 1);
    if (!wr) check(m_rdata == exp_rd(a), "R9 read data", m_rdata, exp_rd(a));
    if (wr) check(m_tail == exp_tail, "R11 write tail", m_tail, exp_tail);
    else    check(m_tail == exp_tail, "R10 read tail", m_tail, exp_tail);
    repeat (2) wait_neg();
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    #1;
    // R1: reset state
    check(mem_ce_no && mem_oe_no && mem_re_no && mem_we_no, "R1 strobes idle", {mem_ce_no, mem_oe_no, mem_re_no, mem_we_no}, 4'hF);
    check(mem_be_no == '1 && !mem_wdata_oe_o && !rsp_done_o, "R1 enables idle", {mem_be_no, mem_wdata_oe_o, rsp_done_o}, 6'h3C);
    check(req_ready_o == 1'b1, "R1 ready after reset", req_ready_o, 1);
    rst_ni = 1'b1;
    repeat (3) wait_neg();

    run_access(0, 2, 3, 2, 0, 0);   // R3 R4 R7 R9 R10
    run_access(1, 0, 0, 0, 0, 0);   // R3 skip, R4 zero as one, R11 zero hold
    run_access(1, 2, 1, 3, 0, 0);   // R11 nonzero hold
    run_access(0, 1, 3, 1, 4, 0);   // R5 stretched to 7
    run_access(1, 1, 2, 1, 5, 0);   // R5 sum 3, no stretch
    run_access(0, 2, 2, 0, 6, 1);   // R6 glitch ignored, width 9
    run_access(0, 0, 2, 9, 0, 0);   // R10 hold >= 7, no tail

    // R2: request while busy is ignored
    begin
      logic [AW-1:0] a0;
      a0 = 20'h1_2345;
      set_cfg(0, 1, 4, 1);
      wait_neg();
      issue(0, a0, 4'hF, '0);
      wait_neg();
      check(req_ready_o == 1'b0, "R2 not ready while busy", req_ready_o, 0);
      req_valid_i = 1'b1; req_addr_i = 20'hF_0F0F; req_write_i = 1'b1;
      wait_neg();
      req_valid_i = 1'b0;
      check(mem_addr_o == a0, "R2 busy request ignored", mem_addr_o, a0);
      wait_idle();
      check(m_mism == 0, "R2 fields stable", m_mism, 0);
      repeat (4) wait_neg();
      check(mem_ce_no == 1'b1, "R2 no extra access", mem_ce_no, 1);
    end

    // R12: request during tail cancels it
    begin
      int guard;
      set_cfg(1, 1, 2, 1);
      set_cfg(0, 1, 2, 2);
      wait_neg();
      issue(1, 20'h0_0AAA, 4'h3, 32'h1234_5678);
      ce_high_seen = 0;
      guard = 0;
      do begin wait_neg(); guard++; end while (m_tail != 2 && guard < 50);
      check(req_ready_o == 1'b1, "R12 ready in tail", req_ready_o, 1);
      issue(0, 20'h0_0BBB, 4'hC, '0);
      wait_neg();
      check(m_prev_tail == 2, "R12 tail cut short", m_prev_tail, 2);
      check(ce_high_seen == 0, "R12 chip enable continuous", ce_high_seen, 0);
      check(m_setup == 1, "R12 new setup starts", m_setup, 1);
      wait_idle();
      check(m_rdata == exp_rd(20'h0_0BBB), "R12 chained read data", m_rdata, exp_rd(20'h0_0BBB));
      repeat (2) wait_neg();
    end

    // random mix
    for (int i = 0; i < 60; i++) begin
      bit wr;
      int s, st, h, rise;
      wr = 1'($urandom);
      s  = $urandom % 4;
      st = $urandom % 6;
      h  = $urandom % 10;
      rise = ($urandom % 2) ? 1 + ($urandom % 6) : 0;
      run_access(wr, s, st, h, rise, 0);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule